// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests from six active-low external lines and from internal event strobes (timer, byte DMA, two serial ports, software, power-down and a reset request). It conditions each external line as edge-triggered or level-triggered and holds edge events and internal strobes in pending latches. It applies a per-source mask and a global enable, and picks the enabled request with the highest priority. The winner's vector address is shown on registered outputs. The core accepts it with a one-cycle `ack`, which clears the matching latch.

Each external line can also be raised by a software flag bit, so a programmable output that shares a pin with an interrupt can trigger that interrupt. The reset request and power-down can never be masked.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `vec_valid` is 0 and `ack_clr` is 0. All pending latches are cleared.
- R2: When `vec_valid` is 1, `vec_addr` equals `VEC_BASE + VEC_STRIDE * index` (default stride 4). The index map is: 0 reset request, 1 power-down, 2 line 0, 3 line 3, 4 line 4, 5 serial port 0, 6 serial port 1, 7 line 5, 8 byte DMA, 9 line 1, 10 line 2, 11 timer, 12 software.
- R3: When several enabled requests are present at once, the lowest index is presented.
- R4: Source index i (i >= 2) is presented only when `mask[i]` = 1 and `glob_en` = 1. A latched request that is masked stays pending and appears once it is enabled.
- R5: The reset request (`rst_evt`) and power-down (`int_evt[5]`) are presented whatever the values of `mask` and `glob_en`.
- R6: An edge-mode line latches a request when its synchronized active-low level falls. The request stays pending after the line returns high, until it is acknowledged.
- R7: A level-mode line requests only while it is low. Nothing is latched, so the request disappears when the line returns high.
- R8: Lines 0, 1 and 2 are edge-mode when `edge_sel[k]` = 1 and level-mode when it is 0. Lines 3 and 4 are always level-mode. Line 5 is always edge-mode.
- R9: `ext_flag[k]` = 1 acts exactly as if line k were driven low. It takes effect at the next clock edge.
- R10: `ack` while `vec_valid` is 1 clears the latch of the presented index. On the next cycle, `ack_clr` is one-hot at that index and the vector output already reflects the remaining requests.
- R11: A new set of a latch in the same cycle as its acknowledge is not lost. The source is presented again.
- R12: An external line change reaches the vector outputs after the third rising edge following the change, and not earlier. An internal strobe reaches them after the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 6 | Active-low external request lines 0..5 |
| ext_flag | input | 6 | Software flags; 1 raises the matching line |
| edge_sel | input | 3 | Mode for lines 0..2: 1 edge, 0 level |
| int_evt | input | 6 | Strobes: 0 timer, 1 byte DMA, 2 serial 0, 3 serial 1, 4 software, 5 power-down |
| rst_evt | input | 1 | Reset-request strobe, index 0 |
| mask | input | 13 | Per-index enable; bits 0 and 1 are ignored |
| glob_en | input | 1 | Global enable for indices 2..12 |
| ack | input | 1 | Core acknowledge of the presented vector |
| vec_valid | output | 1 | A vector is being presented |
| vec_addr | output | 14 | Vector address |
| ack_clr | output | 13 | One-hot marker of the index cleared by the last acknowledge |

## Verification
The main function is exercised with several patterns:
- A held-low level line and a pulsed edge line, where releasing the line shows whether the request was latched.
- A configurable line run in both modes.
- Two simultaneous strobes, where the acknowledge order exposes the priority.
- Masked and globally disabled pending sources, which tell apart retention from loss of the request.
- Power-down and reset requests with everything masked.
- Software flags on a level line and on an edge line.

An acknowledge that coincides with a new strobe of the same source shows whether the set wins over the clear. A sample taken one edge before the expected arrival pins down the synchronizer latency.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NSRC = 13;
  localparam int NEXT = 6;
  localparam int NCFG = 3;
  localparam int NINT = 6;
  localparam int IW   = $clog2(NSRC);

  localparam int IDX_RST  = 0;
  localparam int IDX_PWD  = 1;
  localparam int IDX_X0   = 2;
  localparam int IDX_L3   = 3;
  localparam int IDX_L4   = 4;
  localparam int IDX_SP0  = 5;
  localparam int IDX_SP1  = 6;
  localparam int IDX_X5   = 7;
  localparam int IDX_BDMA = 8;
  localparam int IDX_X1   = 9;
  localparam int IDX_X2   = 10;
  localparam int IDX_TMR  = 11;
  localparam int IDX_SW   = 12;

  localparam int EV_TMR  = 0;
  localparam int EV_BDMA = 1;
  localparam int EV_SP0  = 2;
  localparam int EV_SP1  = 3;
  localparam int EV_SW   = 4;
  localparam int EV_PWD  = 5;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/irq_line_cond.sv
`timescale 1ns/1ps
module irq_line_cond #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] low_sync,
  input  logic [W-1:0] flag,
  input  logic [W-1:0] is_edge,
  output logic [W-1:0] edge_set,
  output logic [W-1:0] lvl_req
);
  logic [W-1:0] active;
  logic [W-1:0] active_q;

  assign active = low_sync | flag;

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active;
  end

  for (genvar k = 0; k < W; k++) begin : g_line
    assign edge_set[k] = is_edge[k] & active[k] & ~active_q[k];
    assign lvl_req[k]  = ~is_edge[k] & active[k];
  end
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int N  = 13,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int              AW         = 14,
  parameter logic [AW-1:0]   VEC_BASE   = '0,
  parameter int              VEC_STRIDE = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_flag,
  input  logic [NCFG-1:0] edge_sel,
  input  logic [NINT-1:0] int_evt,
  input  logic            rst_evt,
  input  logic [NSRC-1:0] mask,
  input  logic            glob_en,
  input  logic            ack,
  output logic            vec_valid,
  output logic [AW-1:0]   vec_addr,
  output logic [NSRC-1:0] ack_clr
);
  logic [NEXT-1:0] low_sync;
  logic [NEXT-1:0] line_edge;
  logic [NEXT-1:0] edge_set;
  logic [NEXT-1:0] lvl_req;
  logic [NSRC-1:0] set_v, lvl_v, keep_v, clr_v, allow_v;
  logic [NSRC-1:0] pend, pend_d, req_v;
  logic            hit;
  logic [IW-1:0]   win_idx, vec_idx;

  irq_sync #(.W(NEXT)) u_sync (
    .clk(clk), .rst(rst), .d(~ext_n), .q(low_sync)
  );

  assign line_edge = {1'b1, 1'b0, 1'b0, edge_sel};

  irq_line_cond #(.W(NEXT)) u_cond (
    .clk(clk), .rst(rst), .low_sync(low_sync), .flag(ext_flag),
    .is_edge(line_edge), .edge_set(edge_set), .lvl_req(lvl_req)
  );

  always_comb begin
    set_v = '0;
    set_v[IDX_RST]  = rst_evt;
    set_v[IDX_PWD]  = int_evt[EV_PWD];
    set_v[IDX_X0]   = edge_set[0];
    set_v[IDX_X1]   = edge_set[1];
    set_v[IDX_X2]   = edge_set[2];
    set_v[IDX_X5]   = edge_set[5];
    set_v[IDX_SP0]  = int_evt[EV_SP0];
    set_v[IDX_SP1]  = int_evt[EV_SP1];
    set_v[IDX_BDMA] = int_evt[EV_BDMA];
    set_v[IDX_TMR]  = int_evt[EV_TMR];
    set_v[IDX_SW]   = int_evt[EV_SW];

    lvl_v = '0;
    lvl_v[IDX_X0] = lvl_req[0];
    lvl_v[IDX_X1] = lvl_req[1];
    lvl_v[IDX_X2] = lvl_req[2];
    lvl_v[IDX_L3] = lvl_req[3];
    lvl_v[IDX_L4] = lvl_req[4];

    keep_v = '1;
    keep_v[IDX_X0] = edge_sel[0];
    keep_v[IDX_X1] = edge_sel[1];
    keep_v[IDX_X2] = edge_sel[2];

    clr_v = '0;
    if (ack && vec_valid) clr_v[vec_idx] = 1'b1;
  end

  // set wins over clear so a same-cycle arrival survives the acknowledge
  assign pend_d  = ((pend & ~clr_v) | set_v) & keep_v;
  assign allow_v = {mask[NSRC-1:2] & {(NSRC-2){glob_en}}, 2'b11};
  assign req_v   = (pend_d | lvl_v) & allow_v;

  irq_prio_enc #(.N(NSRC), .IW(IW)) u_enc (
    .req(req_v), .hit(hit), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      vec_valid <= 1'b0;
      vec_idx   <= '0;
      vec_addr  <= VEC_BASE;
      ack_clr   <= '0;
    end else begin
      pend      <= pend_d;
      vec_valid <= hit;
      vec_idx   <= win_idx;
      vec_addr  <= VEC_BASE + AW'(win_idx) * AW'(VEC_STRIDE);
      ack_clr   <= clr_v;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
`timescale 1ns/1ps
module irq_prio_chk
  import irq_pkg::*;
#(
  parameter int            AW         = 14,
  parameter logic [AW-1:0] VEC_BASE   = '0,
  parameter int            VEC_STRIDE = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NINT-1:0] int_evt,
  input logic            rst_evt,
  input logic [NSRC-1:0] mask,
  input logic            glob_en,
  input logic            ack,
  input logic            vec_valid,
  input logic [AW-1:0]   vec_addr,
  input logic [NSRC-1:0] ack_clr
);
  logic [AW-1:0]   off;
  int              sidx;
  logic [NSRC-1:0] mask_q;
  logic            glob_q;

  assign off  = vec_addr - VEC_BASE;
  assign sidx = int'(off) / VEC_STRIDE;

  always_ff @(posedge clk) begin
    mask_q <= mask;
    glob_q <= glob_en;
  end

  a_r2_addr_in_map: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ((int'(off) % VEC_STRIDE) == 0) && (sidx < NSRC));

  a_r4_mask_gate: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && sidx >= 2 && sidx < NSRC) |-> (glob_q && mask_q[sidx]));

  a_r5_reset_req_top: assert property (@(posedge clk) disable iff (rst)
    $past(rst_evt && !rst) |-> (vec_valid && vec_addr == VEC_BASE));

  a_r5_pwd_unmasked: assert property (@(posedge clk) disable iff (rst)
    $past(int_evt[EV_PWD] && !rst) |-> vec_valid);

  a_r10_clr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_clr));

  a_r10_clr_cause: assert property (@(posedge clk) disable iff (rst)
    (|ack_clr) |-> $past(ack && vec_valid));
endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .AW(AW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk(clk), .rst(rst), .int_evt(int_evt), .rst_evt(rst_evt),
  .mask(mask), .glob_en(glob_en), .ack(ack), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .ack_clr(ack_clr)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int            AW    = 14;
  localparam logic [AW-1:0] BASE  = 14'h0100;
  localparam int            NS    = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [5:0]    ext_n = '1;
  logic [5:0]    ext_flag = '0;
  logic [2:0]    edge_sel = '0;
  logic [5:0]    int_evt = '0;
  logic          rst_evt = 1'b0;
  logic [NS-1:0] mask = '1;
  logic          glob_en = 1'b1;
  logic          ack = 1'b0;
  logic          vec_valid;
  logic [AW-1:0] vec_addr;
  logic [NS-1:0] ack_clr;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.AW(AW), .VEC_BASE(BASE), .VEC_STRIDE(4)) u0 (
    .clk(clk), .rst(rst), .ext_n(ext_n), .ext_flag(ext_flag),
    .edge_sel(edge_sel), .int_evt(int_evt), .rst_evt(rst_evt),
    .mask(mask), .glob_en(glob_en), .ack(ack), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .ack_clr(ack_clr)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_vec(input bit v, input int idx, input string req);
    logic [AW-1:0] ea;
    ea = BASE + AW'(idx * 4);
    n_chk++;
    if (vec_valid !== v || (v && vec_addr !== ea)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, vec_valid, vec_addr, v, v ? ea : vec_addr);
    end
  endtask

  task automatic expect_clr(input logic [NS-1:0] e, input string req);
    n_chk++;
    if (ack_clr !== e) begin
      n_bad++;
      $display("FAIL %s: ack_clr=%b, expected %b", req, ack_clr, e);
    end
  endtask

  task automatic strobe(input int b);
    int_evt[b] = 1'b1;
    step(1);
    int_evt[b] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    expect_vec(1'b0, 0, "R1");
    expect_clr('0, "R1");
  endtask

  task automatic t_level();
    ext_n[3] = 1'b0;
    step(2);
    expect_vec(1'b0, 0, "R12 not before third edge");
    step(1);
    expect_vec(1'b1, 3, "R12/R7 level line 3");
    ext_n[3] = 1'b1;
    step(3);
    expect_vec(1'b0, 0, "R7 level not latched");
  endtask

  task automatic t_edge();
    ext_n[5] = 1'b0;
    step(3);
    expect_vec(1'b1, 7, "R6 edge line 5");
    ext_n[5] = 1'b1;
    step(3);
    expect_vec(1'b1, 7, "R6 held after release");
    do_ack();
    expect_clr(13'(1) << 7, "R10 clear marker");
    expect_vec(1'b0, 0, "R10 latch cleared");
    step(1);
    expect_clr('0, "R10 marker one cycle");
  endtask

  task automatic t_cfg();
    edge_sel[0] = 1'b1;
    ext_n[0] = 1'b0;
    step(3);
    ext_n[0] = 1'b1;
    step(3);
    expect_vec(1'b1, 2, "R8 line 0 edge mode");
    do_ack();
    expect_vec(1'b0, 0, "R8 line 0 acked");
    edge_sel[0] = 1'b0;
    ext_n[0] = 1'b0;
    step(3);
    expect_vec(1'b1, 2, "R8 line 0 level mode low");
    ext_n[0] = 1'b1;
    step(3);
    expect_vec(1'b0, 0, "R8 line 0 level mode released");
  endtask

  task automatic t_prio();
    int_evt = 6'b000101;
    step(1);
    int_evt = '0;
    expect_vec(1'b1, 5, "R3 serial 0 over timer");
    do_ack();
    expect_vec(1'b1, 11, "R3 timer next");
    do_ack();
    expect_vec(1'b0, 0, "R3 all served");
  endtask

  task automatic t_mask();
    mask[11] = 1'b0;
    strobe(0);
    expect_vec(1'b0, 0, "R4 masked timer");
    mask[11] = 1'b1;
    step(1);
    expect_vec(1'b1, 11, "R4 pending retained");
    glob_en = 1'b0;
    step(1);
    expect_vec(1'b0, 0, "R4 global disable");
    glob_en = 1'b1;
    step(1);
    expect_vec(1'b1, 11, "R4 global enable");
    do_ack();
  endtask

  task automatic t_unmaskable();
    mask = '0;
    glob_en = 1'b0;
    strobe(5);
    expect_vec(1'b1, 1, "R5 power-down unmasked");
    rst_evt = 1'b1;
    step(1);
    rst_evt = 1'b0;
    expect_vec(1'b1, 0, "R5/R3 reset request first");
    do_ack();
    expect_vec(1'b1, 1, "R5 power-down after reset req");
    do_ack();
    expect_vec(1'b0, 0, "R5 served");
    mask = '1;
    glob_en = 1'b1;
    step(1);
  endtask

  task automatic t_flag();
    ext_flag[4] = 1'b1;
    step(1);
    expect_vec(1'b1, 4, "R9 flag on level line 4");
    ext_flag[4] = 1'b0;
    step(1);
    expect_vec(1'b0, 0, "R9 flag removed");
    ext_flag[5] = 1'b1;
    step(1);
    ext_flag[5] = 1'b0;
    step(1);
    expect_vec(1'b1, 7, "R9 flag edge latched");
    do_ack();
    expect_vec(1'b0, 0, "R9 edge acked");
  endtask

  task automatic t_race();
    strobe(0);
    expect_vec(1'b1, 11, "R11 timer presented");
    ack = 1'b1;
    int_evt[0] = 1'b1;
    step(1);
    ack = 1'b0;
    int_evt[0] = 1'b0;
    expect_clr(13'(1) << 11, "R11 ack marker");
    expect_vec(1'b1, 11, "R11 new set kept");
    do_ack();
    expect_vec(1'b0, 0, "R11 second ack");
  endtask

  initial begin
    step(3);
    t_reset();
    rst = 1'b0;
    step(1);
    t_reset();
    t_level();
    t_edge();
    t_cfg();
    t_prio();
    t_mask();
    t_unmaskable();
    t_flag();
    t_race();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule